// File: doc/BRIEF.md
# Dual Countdown Timer with Free-Running Timestamp

This peripheral combines a 32-bit up-counter that advances on every clock with two separate 32-bit countdown timers. Software reaches all of it through a plain word-wide register port: one write strobe with address and data, and a read path that returns the addressed register in the same cycle. Each countdown timer has one control word. Its two low bits hold the run flag and the single-expiry flag, and the upper thirty bits hold the restart value, whose two low bits are always taken as zero.

An expiring timer, or the timestamp rolling over, raises a sticky flag in a shared status word. Software clears a flag by writing a one to its bit. The interrupt line stays high while any flag is raised. A timer in periodic mode restarts from its stored value after each expiry. A timer in single-expiry mode stops after the first expiry and drops its own run flag.

Top module: `dual_tick_timer`

## Requirements
- R1: After synchronous reset every mapped register reads zero and `irq` is low.
- R2: The timestamp (offset 0x00) increases by one every clock. A write to 0x00 loads the written value on that edge, and counting resumes from it.
- R3: When the timestamp steps from 0xFFFFFFFF to 0, status bit 2 is set.
- R4: Writing a control word (0x08 for timer 1, 0x10 for timer 2) stores bit 0 as run, bit 1 as single-expiry and bits 31:2 as the restart value. It also loads the current count (0x04 or 0x0C) with that value with bits 1:0 forced to zero. Reading the control word back returns the stored word.
- R5: A running timer whose count is not zero decreases by one per clock. A running timer whose count is zero expires on the next edge and sets its status bit (bit 0 for timer 1, bit 1 for timer 2).
- R6: In periodic mode (bit 1 clear) an expiring timer reloads its restart value, so a restart value V gives one expiry every V+1 clocks.
- R7: In single-expiry mode (bit 1 set) a timer expires once. Its count then stays at zero, and its run bit reads back as zero.
- R8: Writing zero to a control word stops that timer, and its count then holds.
- R9: Writing to the status word (0x20) clears each bit written as one and leaves each bit written as zero. When a bit is set and cleared on the same edge, it ends up set.
- R10: `irq` is high exactly when at least one status bit is set.
- R11: Offsets 0x14, 0x18 and 0x1C read zero, and writes to them have no effect. Writes to the count offsets 0x04 and 0x0C are ignored.
- R12: The two timers run independently: expiry or a write on one leaves the other's count, control word and status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Contents of the addressed register, combinational |
| irq | output | 1 | High while any status bit is set |

## Verification
The in-line properties check on every cycle that the counters move correctly. A running count falls by one, a periodic expiry reloads the restart value, a single expiry drops the run flag, and a stopped count holds. The timestamp steps by one whenever it is not written. A status bit stays set until a write clears it, and unmapped offsets read zero. The bench scenarios are needed for cycle-exact claims: the V+1 period, the exact edge on which a status bit appears, timestamp rollover, and the rule that a set beats a same-edge clear. They are also needed for the independence of the two timers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned OFS_STAMP  = 'h00;
    localparam int unsigned OFS_STATUS = 'h20;

    // timer i: count at 0x04 + 8*i, control word at 0x08 + 8*i
    function automatic int unsigned cnt_ofs(input int unsigned idx);
        return 4 + 8 * idx;
    endfunction

    function automatic int unsigned ctl_ofs(input int unsigned idx);
        return 8 + 8 * idx;
    endfunction

endpackage

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] ctl_word,
    output logic              expire
);

    localparam int RLD_W = DATA_W - 2;

    typedef struct packed {
        logic [RLD_W-1:0]  rld;
        logic              one;
        logic              run;
        logic [DATA_W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      exp_d;

    always_comb begin
        st_d  = st_q;
        exp_d = 1'b0;
        if (ld) begin
            st_d.rld = ld_data[DATA_W-1:2];
            st_d.one = ld_data[1];
            st_d.run = ld_data[0];
            st_d.cnt = {ld_data[DATA_W-1:2], 2'b00};
        end else if (st_q.run) begin
            if (st_q.cnt == '0) begin
                exp_d = 1'b1;
                if (st_q.one) begin
                    st_d.run = 1'b0;
                end else begin
                    st_d.cnt = {st_q.rld, 2'b00};
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign ctl_word = {st_q.rld, st_q.one, st_q.run};
    assign expire   = exp_d;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && st_q.run && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R5

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!ld && st_q.run && !st_q.one && st_q.cnt == '0) |=> (st_q.cnt == {st_q.rld, 2'b00})); // R6

    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (!ld && st_q.run && st_q.one && st_q.cnt == '0) |=> (!st_q.run && st_q.cnt == '0)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ld && !st_q.run) |=> $stable(st_q.cnt)); // R8

endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] value,
    output logic              wrap
);

    typedef struct packed {
        logic [DATA_W-1:0] ts;
    } ts_state_t;

    ts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.ts = ld_data;
        end else begin
            st_d.ts = st_q.ts + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.ts;
    assign wrap  = !ld && (st_q.ts == '1);

    AST_STAMP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !ld |=> (st_q.ts == $past(st_q.ts) + 1'b1)); // R2

    AST_STAMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> (st_q.ts == $past(ld_data))); // R2

endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
    parameter int NUM_FLAGS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] set,
    input  logic [NUM_FLAGS-1:0] clr,
    output logic [NUM_FLAGS-1:0] pend,
    output logic                 irq
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } st_state_t;

    st_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.flags;
    assign irq  = |st_q.flags;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr))); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((pend & $past(set)) == $past(set))); // R9

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int NUM_TMR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    import tmr_pkg::*;

    localparam int NUM_FLAGS = NUM_TMR + 1;
    localparam int TS_BIT    = NUM_TMR;

    logic [DATA_W-1:0]    cnt_w [NUM_TMR];
    logic [DATA_W-1:0]    ctl_w [NUM_TMR];
    logic [NUM_TMR-1:0]   tmr_ld;
    logic [NUM_TMR-1:0]   tmr_exp;
    logic [DATA_W-1:0]    ts_w;
    logic                 ts_ld;
    logic                 ts_wrap;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
            assign tmr_ld[gi] = wr_en && (addr == ADDR_W'(ctl_ofs(gi)));

            tmr_countdown #(
                .DATA_W (DATA_W)
            ) u_cd (
                .clk      (clk),
                .rst      (rst),
                .ld       (tmr_ld[gi]),
                .ld_data  (wdata),
                .count    (cnt_w[gi]),
                .ctl_word (ctl_w[gi]),
                .expire   (tmr_exp[gi])
            );
        end
    endgenerate

    assign ts_ld = wr_en && (addr == ADDR_W'(OFS_STAMP));

    tmr_stamp #(
        .DATA_W (DATA_W)
    ) u_stamp (
        .clk     (clk),
        .rst     (rst),
        .ld      (ts_ld),
        .ld_data (wdata),
        .value   (ts_w),
        .wrap    (ts_wrap)
    );

    always_comb begin
        flag_set         = '0;
        flag_set[TS_BIT] = ts_wrap;
        flag_set[NUM_TMR-1:0] = tmr_exp;
        flag_clr = (wr_en && (addr == ADDR_W'(OFS_STATUS))) ? wdata[NUM_FLAGS-1:0] : '0;
    end

    tmr_status #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_status (
        .clk  (clk),
        .rst  (rst),
        .set  (flag_set),
        .clr  (flag_clr),
        .pend (flag_q),
        .irq  (irq)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STAMP)) begin
            rdata = ts_w;
        end
        if (addr == ADDR_W'(OFS_STATUS)) begin
            rdata = DATA_W'(flag_q);
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr == ADDR_W'(cnt_ofs(i))) begin
                rdata = cnt_w[i];
            end
            if (addr == ADDR_W'(ctl_ofs(i))) begin
                rdata = ctl_w[i];
            end
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr >= ADDR_W'('h14) && addr <= ADDR_W'('h1C)) |-> (rdata == '0)); // R11

    AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (rdata == '0 && addr == ADDR_W'(OFS_STATUS)) |-> !irq); // R10

endmodule

// File: tb/dual_tick_timer_bench.sv
`timescale 1ns/100ps
module dual_tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_tick_timer u_dual_tick_timer (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // {write, addr, data (write data or expected read), requirement number}
    localparam int NV = 15;
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 6'h08, 32'h0000_1236, 4'd4},  // R4 timer 1 stopped, single-expiry
        {1'b0, 6'h08, 32'h0000_1236, 4'd4},
        {1'b0, 6'h04, 32'h0000_1234, 4'd4},
        {1'b1, 6'h10, 32'hABCD_EF02, 4'd4},  // R4 low bits of value forced to zero
        {1'b0, 6'h10, 32'hABCD_EF02, 4'd4},
        {1'b0, 6'h0C, 32'hABCD_EF00, 4'd4},
        {1'b0, 6'h04, 32'h0000_1234, 4'd12}, // R12 timer 1 untouched
        {1'b1, 6'h04, 32'hFFFF_FFFF, 4'd11}, // R11 count offset read-only
        {1'b0, 6'h04, 32'h0000_1234, 4'd11},
        {1'b1, 6'h14, 32'h0000_0005, 4'd11}, // R11 unmapped
        {1'b0, 6'h14, 32'h0000_0000, 4'd11},
        {1'b0, 6'h18, 32'h0000_0000, 4'd11},
        {1'b0, 6'h1C, 32'h0000_0000, 4'd11},
        {1'b1, 6'h08, 32'h0000_0000, 4'd8},  // R8 zero write stops
        {1'b0, 6'h04, 32'h0000_0000, 4'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #0.2;
        d = rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] a0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h04, v); check("R1 count1", v, 0);
        rd(6'h08, v); check("R1 ctl1", v, 0);
        rd(6'h0C, v); check("R1 count2", v, 0);
        step();
        rd(6'h10, v); check("R1 ctl2", v, 0);
        rd(6'h20, v); check("R1 status", v, 0);
        check("R1 irq", 32'(irq), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][42]) begin
                wr(VEC[i][41:36], VEC[i][35:4]);
            end else begin
                step();
                rd(VEC[i][41:36], v);
                check($sformatf("R%0d table[%0d]", VEC[i][3:0], i), v, VEC[i][35:4]);
            end
        end

        // R2 timestamp counting and load
        step();
        rd(6'h00, a0);
        step();
        rd(6'h00, v); check("R2 increment", v, a0 + 1);
        wr(6'h00, 32'h0000_0100);
        rd(6'h00, v); check("R2 load", v, 32'h100);
        step();
        rd(6'h00, v); check("R2 after load", v, 32'h101);

        // R3 rollover
        wr(6'h00, 32'hFFFF_FFFD);
        step();
        step();
        rd(6'h00, v); check("R3 at max", v, 32'hFFFF_FFFF);
        rd(6'h20, v); check("R3 before wrap", v, 0);
        step();
        rd(6'h00, v); check("R3 wrapped", v, 0);
        rd(6'h20, v); check("R3 status bit2", v, 32'h4);
        check("R10 irq raised", 32'(irq), 1);
        wr(6'h20, 32'h0);
        rd(6'h20, v); check("R9 zero write keeps", v, 32'h4);
        wr(6'h20, 32'h4);
        rd(6'h20, v); check("R9 one clears", v, 0);
        check("R10 irq dropped", 32'(irq), 0);

        // R5 R6 periodic timer 1, value 8
        wr(6'h08, 32'h0000_0009);
        rd(6'h04, v); check("R4 count loaded", v, 8);
        for (int k = 1; k <= 18; k++) begin
            step();
            rd(6'h04, v);
            check($sformatf("R5/R6 count k=%0d", k), v, 32'(8 - (k % 9)));
            rd(6'h20, v);
            check($sformatf("R5 status k=%0d", k), v, (k >= 9) ? 32'h1 : 32'h0);
        end
        wr(6'h20, 32'h1);
        rd(6'h20, v); check("R9 clear timer1", v, 0);
        wr(6'h08, 32'h0);
        rd(6'h04, v); a0 = v;
        step();
        step();
        rd(6'h04, v); check("R8 count holds", v, a0);
        rd(6'h20, v); check("R8 no event", v, 0);

        // R9 set wins over same-edge clear
        wr(6'h08, 32'h0000_0001);
        wr(6'h20, 32'h1);
        rd(6'h20, v); check("R9 set beats clear", v, 32'h1);
        wr(6'h08, 32'h0);
        wr(6'h20, 32'h1);
        rd(6'h20, v); check("R9 cleared after stop", v, 0);
        check("R10 irq low", 32'(irq), 0);

        // R7 single-expiry on timer 2, value 4; R12 timer 1 stays idle
        wr(6'h10, 32'h0000_0007);
        for (int k = 1; k <= 8; k++) begin
            step();
            rd(6'h0C, v);
            check($sformatf("R7 count2 k=%0d", k), v, (k >= 4) ? 32'h0 : 32'(4 - k));
            rd(6'h20, v);
            check($sformatf("R7 status k=%0d", k), v, (k >= 5) ? 32'h2 : 32'h0);
        end
        rd(6'h10, v); check("R7 run bit dropped", v, 32'h6);
        step();
        rd(6'h04, v); check("R12 timer1 idle", v, 0);
        rd(6'h08, v); check("R12 ctl1 idle", v, 0);
        check("R10 irq timer2", 32'(irq), 1);
        wr(6'h20, 32'h2);
        rd(6'h20, v); check("R9 clear timer2", v, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule